// File: doc/BRIEF.md
# Pipelined Core-to-Bank Crossbar

This block connects eight requesting cores to nine destinations: eight cache banks (destination codes 0 to 7) and one non-cacheable unit (destination code 8). Each core offers one fixed-width data word per cycle with a destination code. The block stores the word in a small queue reserved for that particular core/destination pair. Each destination has its own output lane. A lane picks one waiting core per cycle in round-robin order and carries the word through a fixed pipeline to its output port. Traffic from different cores to different destinations moves in parallel. Only cores that compete for the same destination wait on each other.

The path for each word has four stages, always in this order. REQUEST writes the word into its pair queue. ARBITRATE registers the grant of the output lane. SELECT reads the granted queue head, which leaves the queue, and registers it. TRANSMIT drives the output register. Each pair queue is a three-state machine. Q_EMPTY moves to Q_ONE on a push. Q_ONE moves to Q_FULL on a push without a pop, and to Q_EMPTY on a pop without a push. A push and a pop together keep it in Q_ONE. Q_FULL moves to Q_ONE on a pop and never accepts a push. A core's ready is low while the queue for its presented destination is in Q_FULL.

Top module: `core_bank_xbar`

## Requirements
- R1: After reset, every output valid is low, and every core presenting destination 0 sees ready high.
- R2: Take a word accepted (valid and ready both high) in clock cycle t, with no competing traffic for its destination. It appears at its destination in cycle t+4, valid for exactly one cycle.
- R3: Each core/destination pair buffers at most two words. Ready is computed from the queue state at the start of the cycle; a pop at the same edge does not count. Ready is low while that pair's queue holds two words. A full queue for one destination does not lower ready for a different destination or core.
- R4: Words from different cores to different destinations, accepted in the same cycle, all appear together in the same later cycle.
- R5: Each destination delivers at most one word per cycle. With several cores waiting, the destination delivers one word in every cycle until none remain.
- R6: Among waiting cores, the grant goes to the first waiting core at or after the core following the last one granted, wrapping from 7 to 0. After reset the search starts at core 0.
- R7: The round-robin position changes only in cycles in which a grant is issued. Idle cycles leave the order unchanged.
- R8: Words from one core to one destination come out in the order they were accepted. Every accepted word is delivered exactly once.
- R9: Destination code 8 is the non-cacheable unit and behaves like a bank. Codes 9 to 15 are never accepted: ready stays low and no output is produced.
- R10: With each delivered word, the destination's source field carries the number (0 to 7) of the core that sent it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 8 | Per core: a word is offered |
| src_dest | input | 32 | Per core, 4 bits each: destination code (0-7 banks, 8 non-cacheable unit) |
| src_data | input | 256 | Per core, 32 bits each: data word |
| src_ready | output | 8 | Per core: the offered word is taken at this edge |
| dst_valid | output | 9 | Per destination: a word is delivered this cycle |
| dst_src | output | 27 | Per destination, 3 bits each: number of the sending core |
| dst_data | output | 288 | Per destination, 32 bits each: delivered data word |

## Verification
Assertions check the following on every cycle:
- No pair queue is pushed while full or popped while empty.
- Every grant goes to a core that is eligible.
- An output lane never idles while any eligible core is waiting.
- The round-robin position holds through cycles without a grant.
- A delivered word always traces back through the arbitrate and select stages.

Only the bench's scenarios can show the rest:
- The exact four-cycle timing.
- Which core wins under contention after a given history.
- That FIFO order and delivery hold per pair.
- That stalls stay local to one pair.
- That codes above 8 are refused.

A scoreboard keyed by core and destination supports these checks.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_ONE   = 2'd1,
        Q_FULL  = 2'd2
    } pq_state_e;

endpackage

// File: rtl/xbar_pair_queue.sv
module xbar_pair_queue
    import xbar_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic              full,
    output logic              nonempty
);

    pq_state_e state_q, state_d;
    logic [DATA_W-1:0] slot0_q, slot1_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: if (push) state_d = Q_ONE;
            Q_ONE: begin
                if (push && !pop)      state_d = Q_FULL;
                else if (!push && pop) state_d = Q_EMPTY;
            end
            Q_FULL: if (pop) state_d = Q_ONE;
            default: state_d = Q_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    // storage: slot0 is always the head
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot0_q <= '0;
            slot1_q <= '0;
        end else begin
            unique case (state_q)
                Q_EMPTY: if (push) slot0_q <= push_data;
                Q_ONE: begin
                    if (push && pop) slot0_q <= push_data;
                    else if (push)   slot1_q <= push_data;
                end
                Q_FULL: if (pop) slot0_q <= slot1_q;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        head_data = slot0_q;
        full      = (state_q == Q_FULL);
        nonempty  = (state_q != Q_EMPTY);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (state_q != Q_FULL)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (state_q != Q_EMPTY)); // R8

endmodule

// File: rtl/xbar_rr_arbiter.sv
module xbar_rr_arbiter #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic             gnt_vld,
    output logic [IDX_W-1:0] gnt_idx
);

    logic [IDX_W-1:0] ptr_q;

    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int off = 0; off < N; off++) begin
            int cand;
            cand = int'(ptr_q) + off;
            if (cand >= N) cand = cand - N;
            if (!gnt_vld && req[cand]) begin
                gnt_vld = 1'b1;
                gnt_idx = IDX_W'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (gnt_vld) begin
            if (int'(gnt_idx) == N - 1) ptr_q <= '0;
            else                        ptr_q <= gnt_idx + IDX_W'(1);
        end
    end

    AST_GRANT_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> req[gnt_idx]); // R6
    AST_WORK_CONSERVING: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> gnt_vld); // R5
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_vld |=> $stable(ptr_q)); // R7

endmodule

// File: rtl/xbar_out_lane.sv
module xbar_out_lane #(
    parameter int N_SRC  = 8,
    parameter int DATA_W = 32,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_SRC-1:0]              q_nonempty,
    input  logic [N_SRC-1:0]              q_full,
    input  logic [N_SRC-1:0][DATA_W-1:0]  q_head,
    output logic [N_SRC-1:0]              q_pop,
    output logic                          out_valid,
    output logic [SRC_W-1:0]              out_src,
    output logic [DATA_W-1:0]             out_data
);

    // arbitrate stage
    logic             arb_vld;
    logic [SRC_W-1:0] arb_src;
    // select stage
    logic              sel_vld;
    logic [SRC_W-1:0]  sel_src;
    logic [DATA_W-1:0] sel_data;
    // transmit stage
    logic              tx_vld;
    logic [SRC_W-1:0]  tx_src;
    logic [DATA_W-1:0] tx_data;

    logic [N_SRC-1:0] eligible;
    logic             gnt_vld;
    logic [SRC_W-1:0] gnt_idx;

    // a granted word stays in its queue until the select stage pops it,
    // so that source needs a second entry to be eligible again
    always_comb begin
        for (int s = 0; s < N_SRC; s++) begin
            if (arb_vld && (arb_src == SRC_W'(s))) eligible[s] = q_full[s];
            else                                   eligible[s] = q_nonempty[s];
        end
    end

    xbar_rr_arbiter #(.N(N_SRC)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (eligible),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    always_comb begin
        q_pop = '0;
        if (arb_vld) q_pop[arb_src] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_vld  <= 1'b0;
            arb_src  <= '0;
            sel_vld  <= 1'b0;
            sel_src  <= '0;
            sel_data <= '0;
            tx_vld   <= 1'b0;
            tx_src   <= '0;
            tx_data  <= '0;
        end else begin
            arb_vld  <= gnt_vld;
            arb_src  <= gnt_idx;
            sel_vld  <= arb_vld;
            sel_src  <= arb_src;
            sel_data <= q_head[arb_src];
            tx_vld   <= sel_vld;
            tx_src   <= sel_src;
            tx_data  <= sel_data;
        end
    end

    always_comb begin
        out_valid = tx_vld;
        out_src   = tx_src;
        out_data  = tx_data;
    end

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        arb_vld |-> q_nonempty[arb_src]); // R8
    AST_STAGE_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(arb_vld, 2)); // R2

endmodule

// File: rtl/core_bank_xbar.sv
module core_bank_xbar #(
    parameter int N_SRC  = 8,
    parameter int N_DST  = 9,
    parameter int DATA_W = 32,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int DST_W = (N_DST > 1) ? $clog2(N_DST) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SRC-1:0]          src_valid,
    input  logic [N_SRC*DST_W-1:0]    src_dest,
    input  logic [N_SRC*DATA_W-1:0]   src_data,
    output logic [N_SRC-1:0]          src_ready,
    output logic [N_DST-1:0]          dst_valid,
    output logic [N_DST*SRC_W-1:0]    dst_src,
    output logic [N_DST*DATA_W-1:0]   dst_data
);

    logic [N_DST-1:0][N_SRC-1:0]             q_push;
    logic [N_DST-1:0][N_SRC-1:0]             q_pop;
    logic [N_DST-1:0][N_SRC-1:0]             q_full;
    logic [N_DST-1:0][N_SRC-1:0]             q_nonempty;
    logic [N_DST-1:0][N_SRC-1:0][DATA_W-1:0] q_head;

    // ready and push steering: codes at or above N_DST match no lane
    always_comb begin
        src_ready = '0;
        q_push    = '0;
        for (int s = 0; s < N_SRC; s++) begin
            for (int d = 0; d < N_DST; d++) begin
                if (src_dest[s*DST_W +: DST_W] == DST_W'(d)) begin
                    src_ready[s] = !q_full[d][s];
                    q_push[d][s] = src_valid[s] && !q_full[d][s];
                end
            end
        end
    end

    for (genvar d = 0; d < N_DST; d++) begin : g_dst
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            xbar_pair_queue #(.DATA_W(DATA_W)) u_q (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (q_push[d][s]),
                .push_data (src_data[s*DATA_W +: DATA_W]),
                .pop       (q_pop[d][s]),
                .head_data (q_head[d][s]),
                .full      (q_full[d][s]),
                .nonempty  (q_nonempty[d][s])
            );
        end

        xbar_out_lane #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .q_nonempty (q_nonempty[d]),
            .q_full     (q_full[d]),
            .q_head     (q_head[d]),
            .q_pop      (q_pop[d]),
            .out_valid  (dst_valid[d]),
            .out_src    (dst_src[d*SRC_W +: SRC_W]),
            .out_data   (dst_data[d*DATA_W +: DATA_W])
        );
    end

    AST_READY_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid != '0) |-> ($countones(q_push) <= $countones(src_valid))); // R3
    AST_BAD_CODE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (src_dest[DST_W-1:0] >= DST_W'(N_DST)) |-> !src_ready[0]); // R9

endmodule

// File: tb/core_bank_xbar_bench.sv
`timescale 1ns/1ps
module core_bank_xbar_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   src_valid = '0;
    logic [31:0]  src_dest = '0;
    logic [255:0] src_data = '0;
    logic [7:0]   src_ready;
    logic [8:0]   dst_valid;
    logic [26:0]  dst_src;
    logic [287:0] dst_data;

    core_bank_xbar u_core_bank_xbar (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_dest(src_dest),
        .src_data(src_data), .src_ready(src_ready), .dst_valid(dst_valid),
        .dst_src(dst_src), .dst_data(dst_data)
    );

    always #10 clk = ~clk;

    int n_vec = 0;
    int n_miss = 0;
    int cyc = 0;
    int acc_cyc = 0;
    logic [7:0] last_rdy;
    logic        tv [8];
    logic [3:0]  td [8];
    logic [31:0] tdat [8];
    logic [31:0] exp_q [72][$];
    int log7_src [$];
    int log7_cyc [$];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_vec++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic clear_req();
        for (int s = 0; s < 8; s++) begin tv[s] = 1'b0; td[s] = 4'd0; tdat[s] = '0; end
    endtask

    // driver: called at a negedge, records accepted words in the scoreboard
    task automatic apply();
        for (int s = 0; s < 8; s++) begin
            src_valid[s] = tv[s];
            src_dest[s*4 +: 4] = td[s];
            src_data[s*32 +: 32] = tdat[s];
        end
        #2;
        last_rdy = src_ready;
        acc_cyc = cyc;
        for (int s = 0; s < 8; s++)
            if (tv[s] && src_ready[s]) exp_q[s*9 + int'(td[s])].push_back(tdat[s]);
        @(negedge clk);
        src_valid = '0;
        clear_req();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the scoreboard on every delivery (R8, R10)
    initial forever begin
        @(negedge clk);
        cyc++;
        #5;
        if (rst_n) begin
            for (int d = 0; d < 9; d++) begin
                if (dst_valid[d]) begin
                    int s;
                    logic [31:0] got, expd;
                    s = int'(dst_src[d*3 +: 3]);
                    got = dst_data[d*32 +: 32];
                    if (d == 7) begin log7_src.push_back(s); log7_cyc.push_back(cyc); end
                    if (exp_q[s*9 + d].size() == 0) begin
                        check(1'b0, "R10 delivery with no pending word for src/dst", {28'd0, 4'(d), got}, 64'd0);
                    end else begin
                        expd = exp_q[s*9 + d].pop_front();
                        check(got == expd, "R8 pair order/data", 64'(got), 64'(expd));
                    end
                end
            end
        end
    end

    initial begin
        #(20 * 150000);
        n_miss++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        int t0;
        logic [31:0] lfsr;
        int seq;
        clear_req();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        check(dst_valid == 9'd0, "R1 outputs idle after reset", 64'(dst_valid), 64'd0);
        check(src_ready == 8'hFF, "R1 ready after reset", 64'(src_ready), 64'hFF);
        @(negedge clk);

        // R2: single uncontended word, core 2 -> bank 5
        tv[2] = 1'b1; td[2] = 4'd5; tdat[2] = 32'hA5A50002;
        apply();
        for (int k = 1; k <= 5; k++) begin
            #3;
            check(dst_valid[5] == (k == 4), "R2 four-cycle latency", 64'(dst_valid[5]), 64'(k == 4));
            @(negedge clk);
        end

        // R4: core i -> bank i for all eight in one cycle
        for (int s = 0; s < 8; s++) begin tv[s] = 1'b1; td[s] = 4'(s); tdat[s] = 32'h10000000 + s; end
        apply();
        repeat (3) @(negedge clk);
        #3;
        check(dst_valid == 9'h0FF, "R4 parallel delivery", 64'(dst_valid), 64'h0FF);
        for (int d = 0; d < 8; d++)
            check(dst_src[d*3 +: 3] == 3'(d), "R10 source field", 64'(dst_src[d*3 +: 3]), 64'(d));
        @(negedge clk);
        idle(3);

        // prime bank 7: last grant core 5
        tv[5] = 1'b1; td[5] = 4'd7; tdat[5] = 32'h70000005;
        apply();
        idle(6);

        // R5/R6: all cores to bank 7 at once
        log7_src.delete(); log7_cyc.delete();
        for (int s = 0; s < 8; s++) begin tv[s] = 1'b1; td[s] = 4'd7; tdat[s] = 32'h77000000 + s; end
        apply();
        t0 = acc_cyc;
        idle(14);
        check(log7_src.size() == 8, "R5 all contenders delivered", 64'(log7_src.size()), 64'd8);
        for (int k = 0; k < 8 && k < log7_src.size(); k++) begin
            check(log7_src[k] == ((6 + k) % 8), "R6 round-robin order", 64'(log7_src[k]), 64'((6 + k) % 8));
            check(log7_cyc[k] == t0 + 4 + k, "R5 one word per cycle", 64'(log7_cyc[k]), 64'(t0 + 4 + k));
        end

        // R7: idle gap must not move the order; last grant was core 5
        idle(5);
        log7_src.delete(); log7_cyc.delete();
        tv[1] = 1'b1; td[1] = 4'd7; tdat[1] = 32'h71000001;
        tv[6] = 1'b1; td[6] = 4'd7; tdat[6] = 32'h71000006;
        apply();
        idle(8);
        check(log7_src.size() == 2, "R7 two delivered", 64'(log7_src.size()), 64'd2);
        if (log7_src.size() == 2) begin
            check(log7_src[0] == 6, "R7 order kept over idle", 64'(log7_src[0]), 64'd6);
            check(log7_src[1] == 1, "R7 second grant", 64'(log7_src[1]), 64'd1);
        end

        // R3: core 0 -> bank 2 three times; stall on the third, core 1 unaffected
        tv[0] = 1'b1; td[0] = 4'd2; tdat[0] = 32'h20000001;
        apply();
        check(last_rdy[0] == 1'b1, "R3 ready with empty queue", 64'(last_rdy[0]), 64'd1);
        tv[0] = 1'b1; td[0] = 4'd2; tdat[0] = 32'h20000002;
        apply();
        check(last_rdy[0] == 1'b1, "R3 ready with one entry", 64'(last_rdy[0]), 64'd1);
        tv[0] = 1'b1; td[0] = 4'd2; tdat[0] = 32'h20000003;
        tv[1] = 1'b1; td[1] = 4'd3; tdat[1] = 32'h31000001;
        apply();
        check(last_rdy[0] == 1'b0, "R3 stall when pair queue full", 64'(last_rdy[0]), 64'd0);
        check(last_rdy[1] == 1'b1, "R3 other pair not stalled", 64'(last_rdy[1]), 64'd1);
        tv[0] = 1'b1; td[0] = 4'd2; tdat[0] = 32'h20000003;
        apply();
        check(last_rdy[0] == 1'b1, "R3 ready after pop", 64'(last_rdy[0]), 64'd1);
        idle(8);

        // R8: ordered burst from core 4 to bank 0 with a competitor on core 6
        begin
            int k4, k6;
            k4 = 0; k6 = 0;
            while (k4 < 6 || k6 < 6) begin
                if (k4 < 6) begin tv[4] = 1'b1; td[4] = 4'd0; tdat[4] = 32'h40000000 + k4; end
                if (k6 < 6) begin tv[6] = 1'b1; td[6] = 4'd0; tdat[6] = 32'h60000000 + k6; end
                apply();
                if (k4 < 6 && last_rdy[4]) k4++;
                if (k6 < 6 && last_rdy[6]) k6++;
            end
        end
        idle(10);
        check(exp_q[4*9 + 0].size() == 0, "R8 burst fully delivered", 64'(exp_q[36].size()), 64'd0);

        // R9: non-cacheable unit and refused codes
        tv[3] = 1'b1; td[3] = 4'd8; tdat[3] = 32'h80000003;
        apply();
        repeat (3) @(negedge clk);
        #3;
        check(dst_valid == 9'h100, "R9 non-cacheable unit delivery", 64'(dst_valid), 64'h100);
        check(dst_src[24 +: 3] == 3'd3, "R10 source field on unit 8", 64'(dst_src[24 +: 3]), 64'd3);
        @(negedge clk);
        idle(2);
        tv[2] = 1'b1; td[2] = 4'd9;  tdat[2] = 32'h90000002;
        tv[5] = 1'b1; td[5] = 4'd15; tdat[5] = 32'hF0000005;
        apply();
        check(last_rdy[2] == 1'b0, "R9 code 9 refused", 64'(last_rdy[2]), 64'd0);
        check(last_rdy[5] == 1'b0, "R9 code 15 refused", 64'(last_rdy[5]), 64'd0);
        for (int k = 0; k < 6; k++) begin
            #3;
            check(dst_valid == 9'd0, "R9 no output for bad code", 64'(dst_valid), 64'd0);
            @(negedge clk);
        end

        // mixed traffic
        lfsr = 32'h1ACE2B3D;
        seq = 0;
        for (int it = 0; it < 400; it++) begin
            for (int s = 0; s < 8; s++) begin
                lfsr = lfsr ^ (lfsr << 13);
                lfsr = lfsr ^ (lfsr >> 17);
                lfsr = lfsr ^ (lfsr << 5);
                tv[s] = lfsr[0] & lfsr[1];
                td[s] = 4'(lfsr[15:8] % 8'd9);
                tdat[s] = {8'(s), 24'(seq)};
                seq++;
            end
            apply();
        end
        idle(20);
        begin
            int left;
            left = 0;
            for (int i = 0; i < 72; i++) left += exp_q[i].size();
            check(left == 0, "R8 every accepted word delivered", 64'(left), 64'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule